// File: doc/BRIEF.md
# Three-Channel Match Timer

This block holds a bank of independent up-counters behind a small register port. Each counter has a bank of match comparators, and each comparator has its own sticky status bit and its own interrupt enable. A per-channel mode bit sets what a counter does when match 0 fires. In periodic mode the count restarts at zero on that tick. In free-running mode the count keeps going and wraps at 2^32. Each counter advances only on the tick enable that its 2-bit clock-select field picks from the `tick_src` inputs. One shared interrupt line is raised whenever any enabled status bit is set.

Software does not read a counter directly. It writes 1 to the channel's capture register, which takes a snapshot of the count. After a fixed settling delay a capture-valid bit comes up, and only then does the capture register return the snapshot. The run register has one bit per channel, so one write can start or stop any subset of counters. To get a timeout of N ticks, software writes N-1 to a match register.

The address is split into a block field `reg_addr[5:3]` and an offset `reg_addr[2:0]`. Block 0 holds the global registers: run at offset 0, clock select at 1, mode at 2 and capture-valid at 3. Block c+1 belongs to channel c: match 0..2 at offsets 0..2, status at 3, interrupt enable at 4 and capture at 5.

Top module: `match_timer_bank`

## Requirements
- R1: Match values (offsets 0..2), interrupt enables (offset 4), run (global 0), clock select (global 1) and mode (global 2) read back the last value written. A write takes effect at the clock edge that samples it, and reads are combinational.
- R2: Bits [2c+1:2c] of the clock-select register give the `tick_src` index for channel c. An enabled counter advances by one only in cycles where its selected tick input is 1.
- R3: Run bit c enables channel c. A write that takes the bit from 0 to 1 sets the count to 0. While the bit is 0 the count holds and no status bit is set.
- R4: Status bit m of a channel is set on the tick in which the count equals match value m. With match 0 = N-1 and a start from 0, bit 0 sets on the N-th tick and not before.
- R5: With mode bit c = 1 the count goes to 0 on the tick that hits match 0. With mode bit c = 0 it increments past the match and wraps modulo 2^32.
- R6: Writing 1 to a status bit (offset 3) clears it. A match in the same cycle wins, and the bit stays set.
- R7: `irq` is 1 exactly when some channel has a status bit set whose enable bit is also set.
- R8: Writing a 1 in bit 0 to a channel's capture offset takes a snapshot of the count. The capture-valid bit c (global 3) is 0 for the first 3 cycles after that write and becomes 1 in the 4th. The capture register reads 0 until the bit is valid and the snapshot after that.
- R9: Synchronous active-low reset sets all of the above registers, counts and status bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 6 | Register address (block, offset) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_src | input | 4 | Tick enables selectable per channel |
| irq | output | 1 | Shared interrupt request |

## Verification
Two events can land on a status bit in the same cycle: a comparator hit and a software write-1-to-clear. The bench provokes the collision on a channel that ticks every cycle, with match 0 set to 1. It starts the channel and idles one cycle, so that the clear write is sampled at exactly the edge where the count passes 1. The bit must still read as set afterwards, and `irq` must be high. A later clear with no hit must drop both.

// File: rtl/mtb_pkg.sv
`timescale 1ns/1ps
// Package: shared address layout of the match timer bank.
// Assumes at most three match comparators per channel (offsets 0..2).
package mtb_pkg;
    localparam int OFF_W = 3;

    // Offsets inside a channel block
    typedef enum logic [OFF_W-1:0] {
        OFF_MATCH0  = 3'd0,
        OFF_MATCH1  = 3'd1,
        OFF_MATCH2  = 3'd2,
        OFF_STATUS  = 3'd3,
        OFF_IEN     = 3'd4,
        OFF_CAPTURE = 3'd5
    } ch_off_e;

    // Offsets inside the global block
    typedef enum logic [OFF_W-1:0] {
        G_RUN     = 3'd0,
        G_CLKSEL  = 3'd1,
        G_MODE    = 3'd2,
        G_CAPSTAT = 3'd3
    } glob_off_e;
endpackage

// File: rtl/mtb_capture.sv
`timescale 1ns/1ps
// Module: mtb_capture
// Takes a snapshot of a count on request and reports it valid after DELAY
// cycles. Assumes DELAY >= 1. The value reads as zero while not valid.
module mtb_capture #(
    parameter int CNT_W = 32,
    parameter int DELAY = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output logic [CNT_W-1:0] value
);
    localparam int DLY_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] snap_q;
    logic [DLY_W-1:0] wait_q;

    // Snapshot on request, then count down the settling delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            wait_q <= '0;
            valid  <= 1'b0;
        end else if (req) begin
            snap_q <= count;
            wait_q <= DLY_W'(DELAY);
            valid  <= 1'b0;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
            if (wait_q == DLY_W'(1))
                valid <= 1'b1;
        end
    end

    // Hide the snapshot until it has settled
    assign value = valid ? snap_q : '0;

    AST_REQ_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !valid); // R8
    AST_VALID_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (wait_q == '0) && !$past(req)); // R8
endmodule

// File: rtl/mtb_channel.sv
`timescale 1ns/1ps
// Module: mtb_channel
// One up-counter with NUM_MATCH comparators, sticky status and enables.
// Assumes `start` only pulses on a 0->1 run transition (run still 0 then)
// and that NUM_SRC equals 2**SEL_W.
module mtb_channel #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 3,
    parameter int SEL_W     = 2,
    parameter int NUM_SRC   = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       start,
    input  logic                       periodic,
    input  logic [SEL_W-1:0]           sel,
    input  logic [NUM_SRC-1:0]         tick_src,
    input  logic [NUM_MATCH-1:0]       match_wr,
    input  logic                       ien_wr,
    input  logic [NUM_MATCH-1:0]       status_clr,
    input  logic [CNT_W-1:0]           wdata,
    output logic [NUM_MATCH*CNT_W-1:0] match_flat,
    output logic [NUM_MATCH-1:0]       status,
    output logic [NUM_MATCH-1:0]       ien,
    output logic [CNT_W-1:0]           count,
    output logic                       irq_req
);
    logic                 tick;
    logic [NUM_MATCH-1:0] hit;

    // A tick counts only while enabled and on the selected source
    assign tick = run && tick_src[sel] && !start;

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        logic [CNT_W-1:0] match_q;

        // Comparator value register
        always_ff @(posedge clk) begin
            if (!rst_n)           match_q <= '0;
            else if (match_wr[m]) match_q <= wdata;
        end

        assign hit[m] = tick && (count == match_q);
        assign match_flat[m*CNT_W +: CNT_W] = match_q;

        AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[m] |=> status[m]); // R6
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (status_clr[m] && !hit[m]) |=> !status[m]); // R6
    end

    // Counter: restart on start, reload in periodic mode, else increment
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (start)              count <= '0;
        else if (tick) begin
            if (periodic && hit[0])  count <= '0;
            else                     count <= count + 1'b1;
        end
    end

    // Sticky status: a new hit beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~status_clr) | hit;
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (ien_wr) ien <= wdata[NUM_MATCH-1:0];
    end

    assign irq_req = |(status & ien);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(count)); // R3
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0)); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && periodic && hit[0]) |=> (count == '0)); // R5
    AST_IDLE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((status & ~$past(status)) == '0)); // R3
endmodule

// File: rtl/match_timer_bank.sv
`timescale 1ns/1ps
// Module: match_timer_bank (top)
// Register-mapped bank of match timers with a shared interrupt.
// Address = {block, offset}: block 0 is global, block c+1 is channel c.
// Assumes NUM_CH*SEL_W and NUM_CH fit in CNT_W and NUM_CH < 2**BLK_W.
module match_timer_bank
    import mtb_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_MATCH = 3,
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 2,
    parameter int CAP_DELAY = 4,
    parameter int ADDR_W    = 6
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [CNT_W-1:0]        reg_wdata,
    output logic [CNT_W-1:0]        reg_rdata,
    input  logic [(2**SEL_W)-1:0]   tick_src,
    output logic                    irq
);
    localparam int NUM_SRC = 2**SEL_W;
    localparam int BLK_W   = ADDR_W - OFF_W;

    logic [BLK_W-1:0]        blk;
    logic [OFF_W-1:0]        off;
    logic                    glob_wr;
    logic [NUM_CH-1:0]       run_q, mode_q, start, cap_valid, ch_irq;
    logic [NUM_CH*SEL_W-1:0] clksel_q;

    logic [NUM_MATCH*CNT_W-1:0] ch_match  [NUM_CH];
    logic [NUM_MATCH-1:0]       ch_status [NUM_CH];
    logic [NUM_MATCH-1:0]       ch_ien    [NUM_CH];
    logic [CNT_W-1:0]           ch_count  [NUM_CH];
    logic [CNT_W-1:0]           cap_value [NUM_CH];

    assign blk     = reg_addr[ADDR_W-1:OFF_W];
    assign off     = reg_addr[OFF_W-1:0];
    assign glob_wr = reg_wr && (blk == '0);

    // Global control registers: run, clock select, mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            clksel_q <= '0;
            mode_q   <= '0;
        end else if (glob_wr) begin
            case (off)
                G_RUN:    run_q    <= reg_wdata[NUM_CH-1:0];
                G_CLKSEL: clksel_q <= reg_wdata[NUM_CH*SEL_W-1:0];
                G_MODE:   mode_q   <= reg_wdata[NUM_CH-1:0];
                default:  ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic                 ch_wr;
        logic [NUM_MATCH-1:0] match_wr;

        assign ch_wr    = reg_wr && (blk == BLK_W'(c + 1));
        assign start[c] = glob_wr && (off == G_RUN) && reg_wdata[c] && !run_q[c];

        for (genvar m = 0; m < NUM_MATCH; m++) begin : g_mw
            assign match_wr[m] = ch_wr && (off == OFF_W'(m));
        end

        mtb_channel #(
            .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .SEL_W(SEL_W), .NUM_SRC(NUM_SRC)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run_q[c]),
            .start      (start[c]),
            .periodic   (mode_q[c]),
            .sel        (clksel_q[c*SEL_W +: SEL_W]),
            .tick_src   (tick_src),
            .match_wr   (match_wr),
            .ien_wr     (ch_wr && (off == OFF_IEN)),
            .status_clr ((ch_wr && (off == OFF_STATUS)) ? reg_wdata[NUM_MATCH-1:0] : '0),
            .wdata      (reg_wdata),
            .match_flat (ch_match[c]),
            .status     (ch_status[c]),
            .ien        (ch_ien[c]),
            .count      (ch_count[c]),
            .irq_req    (ch_irq[c])
        );

        mtb_capture #(.CNT_W(CNT_W), .DELAY(CAP_DELAY)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (ch_wr && (off == OFF_CAPTURE) && reg_wdata[0]),
            .count (ch_count[c]),
            .valid (cap_valid[c]),
            .value (cap_value[c])
        );

        AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            start[c] |=> run_q[c] && (ch_count[c] == '0)); // R3
    end

    // Read mux: global block or addressed channel block
    always_comb begin
        reg_rdata = '0;
        if (blk == '0) begin
            case (off)
                G_RUN:     reg_rdata[NUM_CH-1:0]       = run_q;
                G_CLKSEL:  reg_rdata[NUM_CH*SEL_W-1:0] = clksel_q;
                G_MODE:    reg_rdata[NUM_CH-1:0]       = mode_q;
                G_CAPSTAT: reg_rdata[NUM_CH-1:0]       = cap_valid;
                default:   ;
            endcase
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (blk == BLK_W'(c + 1)) begin
                    if (int'(off) < NUM_MATCH)
                        reg_rdata = ch_match[c][int'(off)*CNT_W +: CNT_W];
                    else begin
                        case (off)
                            OFF_STATUS:  reg_rdata[NUM_MATCH-1:0] = ch_status[c];
                            OFF_IEN:     reg_rdata[NUM_MATCH-1:0] = ch_ien[c];
                            OFF_CAPTURE: reg_rdata = cap_value[c];
                            default:     ;
                        endcase
                    end
                end
            end
        end
    end

    // Shared interrupt: any channel with an enabled pending match
    assign irq = |ch_irq;

    AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R9
endmodule

// File: tb/test_match_timer_bank.sv
`timescale 1ns/1ps
module test_match_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tick_src = 4'b0001;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    match_timer_bank i_match_timer_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_src(tick_src), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Vector: {read?, addr, data/expected}
    localparam int NV = 21;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'd1,  32'h15}, {1'b1, 6'd1,  32'h15},
        {1'b0, 6'd2,  32'h2},  {1'b1, 6'd2,  32'h2},
        {1'b0, 6'd8,  32'h4},  {1'b1, 6'd8,  32'h4},
        {1'b0, 6'd9,  32'h100},{1'b1, 6'd9,  32'h100},
        {1'b0, 6'd10, 32'hDEADBEEF}, {1'b1, 6'd10, 32'hDEADBEEF},
        {1'b0, 6'd12, 32'h7},  {1'b1, 6'd12, 32'h7},
        {1'b0, 6'd16, 32'h2},  {1'b0, 6'd17, 32'h1},
        {1'b0, 6'd18, 32'h50}, {1'b1, 6'd18, 32'h50},
        {1'b1, 6'd17, 32'h1},  {1'b1, 6'd16, 32'h2},
        {1'b1, 6'd0,  32'h0},  {1'b1, 6'd11, 32'h0},
        {1'b1, 6'd20, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            tick_src[idx] = 1'b1;
            @(negedge clk);
            tick_src[idx] = 1'b0;
        end
    endtask

    // Capture request, then valid must appear in the 4th cycle (R8)
    task automatic cap_chk(input int ch, input logic [31:0] exp, input string tag);
        logic [5:0] a;
        a = 6'((ch + 1) * 8 + 5);
        wr(a, 32'h1);
        repeat (3) @(negedge clk);
        reg_addr = 6'd3; #1;
        check({"R8 valid early ", tag}, 32'(reg_rdata[ch]), 32'h0);
        rd(a, 32'h0, {"R8 value early ", tag});
        @(negedge clk);
        reg_addr = 6'd3; #1;
        check({"R8 valid late ", tag}, 32'(reg_rdata[ch]), 32'h1);
        rd(a, exp, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd(6'd0, 32'h0, "R9 run");
        rd(6'd13, 32'h0, "R9 capture");
        check("R9 irq", 32'(irq), 32'h0);

        // R1 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) rd(VEC[i][37:32], VEC[i][31:0], "R1 table");
            else            wr(VEC[i][37:32], VEC[i][31:0]);
        end

        // ch0 <- src2, ch1 <- src3, ch2 <- src1 (never ticks)
        wr(6'd1, 32'h1E);
        wr(6'd0, 32'h5);
        pulse(2, 4);
        rd(6'd11, 32'h0, "R4 no match before Nth tick");
        pulse(2, 1);
        rd(6'd11, 32'h1, "R4 match on Nth tick");
        check("R7 irq enabled match", 32'(irq), 32'h1);
        cap_chk(0, 32'd5, "R5 free-running passes match");
        cap_chk(2, 32'd0, "R2 unselected source holds count");

        // R7 masking, R6 plain clear
        wr(6'd12, 32'h0);
        check("R7 irq masked", 32'(irq), 32'h0);
        rd(6'd11, 32'h1, "R7 status kept while masked");
        wr(6'd11, 32'h1);
        rd(6'd11, 32'h0, "R6 clear");

        // R5 periodic channel 1
        wr(6'd0, 32'h7);
        pulse(3, 3);
        rd(6'd19, 32'h3, "R4 ch1 matches 0 and 1");
        cap_chk(1, 32'd0, "R5 periodic reload");
        pulse(3, 2);
        cap_chk(1, 32'd2, "R5 periodic recount");

        // R3 disabled hold and restart
        wr(6'd9, 32'd5);
        wr(6'd0, 32'h6);
        pulse(2, 2);
        rd(6'd11, 32'h0, "R3 no status while disabled");
        cap_chk(0, 32'd5, "R3 hold while disabled");
        wr(6'd0, 32'h7);
        cap_chk(0, 32'd0, "R3 restart clears");

        // R6 collision on channel 2 ticking every cycle
        wr(6'd0, 32'h3);
        wr(6'd1, 32'h0E);
        wr(6'd24, 32'd1);
        wr(6'd28, 32'h1);
        wr(6'd0, 32'h7);
        @(negedge clk);
        wr(6'd27, 32'h1);
        rd(6'd27, 32'h7, "R6 match beats clear");
        check("R7 irq after collision", 32'(irq), 32'h1);
        wr(6'd27, 32'h7);
        rd(6'd27, 32'h0, "R6 clear without hit");
        check("R7 irq cleared", 32'(irq), 32'h0);

        // R9 reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(6'd0, 32'h0, "R9 run after reset");
        rd(6'd1, 32'h0, "R9 clksel after reset");
        rd(6'd8, 32'h0, "R9 match after reset");
        rd(6'd3, 32'h0, "R9 capstat after reset");
        check("R9 irq after reset", 32'(irq), 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule